// File: doc/BRIEF.md
# Multi-Lane Vector Add/Subtract Unit

This block carries out one element-wise vector instruction at a time. It adds or subtracts two source vector registers and writes the result into a destination vector register. The vector register file sits inside the block. It holds eight registers of 64 elements each, and every element is a 32-bit two's-complement word. The elements are interleaved over four lanes. Each lane owns the slice of every register whose element index leaves that lane's number as the remainder modulo four. Each lane has its own three-stage pipelined adder/subtractor, so the four lanes together retire one group of four elements per cycle.

A controller pulses `start` with the opcode, the three register indices and the vector length. Only elements below the vector length are processed. The block reports each retiring group on the write-back outputs and raises `done` once the last element has been written. A new instruction is accepted in the same cycle that the previous instruction issues its last group, so the lanes see no dead cycle between instructions. Operands are read when a group issues. Writes still in the pipeline are not forwarded to a later read.

Top module: `vlane_addsub`

## Requirements
- R1: Reset (synchronous, `rst_n` low at a clock edge) clears `done` and `wb_en`. It loads element e of register r with (r * 0x10000000 + e * 0x01000101) mod 2^32.
- R2: With `opcode` 0 each result element is srcA + srcB. With `opcode` 1 it is srcA - srcB. Both wrap modulo 2^32.
- R3: Element e is computed only by lane e mod 4 and retires in group e / 4. On that cycle `wb_en[e mod 4]` is 1, `wb_grp` is e / 4, `wb_vreg` is the destination index, and the result is on `wb_data[32*(e mod 4) +: 32]`.
- R4: Only elements 0 to VL-1 are written, so the enabled lanes of a group always form a prefix starting at lane 0.
- R5: Group g of an instruction accepted at clock edge E appears on the write-back outputs right after edge E+3+g, one group per cycle.
- R6: `done` is high for the one cycle that follows the cycle in which the last group is on the write-back outputs.
- R7: A vector length of 0 writes nothing and raises `done` in the cycle right after the accepting edge.
- R8: A `vlen` value above 64 is processed as 64.
- R9: `start` is accepted when the unit is idle or during the issue cycle of the current instruction's last group. At any other time it is ignored.
- R10: An instruction accepted during the previous one's last issue cycle issues its group 0 in the very next cycle, with no gap.
- R11: Results are stored in the destination register and seen by later instructions that read it. A source may equal the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch pulse for one instruction |
| opcode | input | 1 | 0 = add, 1 = subtract |
| src_a | input | 3 | First source register index |
| src_b | input | 3 | Second source register index |
| dst | input | 3 | Destination register index |
| vlen | input | 7 | Vector length (values above 64 clamp to 64) |
| done | output | 1 | Instruction complete |
| wb_en | output | 4 | Per-lane write-back strobe |
| wb_vreg | output | 3 | Register being written |
| wb_grp | output | 4 | Element group being written |
| wb_data | output | 128 | Per-lane results, lane k at bits 32k+31..32k |

## Verification
The bench builds the unit with its default parameters: four lanes, eight registers, 64-element registers and 32-bit elements. These give 16 groups per full-length instruction. That brings into reach the full register length, partial final groups of one to three lanes, a single-group instruction whose first issue is also its last, and a length above the register size. The reset contents give large register values, so adding the two highest registers carries out of 32 bits and exercises the wrap. Back-to-back, ignored and in-place instructions are run, and every result is later re-read as a source.

// File: rtl/vlane_pkg.sv
`timescale 1ns/1ps
// Package: shared opcode type and the reset contents of the register file.
// Assumes element values fit in 64 bits before truncation to the element width.
package vlane_pkg;

    typedef enum logic {
        VOP_ADD = 1'b0,
        VOP_SUB = 1'b1
    } vop_e;

    // Reset value of one register element (caller truncates to its width).
    function automatic logic [63:0] seed_word(input int unsigned vreg, input int unsigned elem);
        return (64'(vreg) << 28) + (64'(elem) * 64'h0000_0000_0100_0101);
    endfunction

endpackage

// File: rtl/vlane_seq.sv
`timescale 1ns/1ps
// Issue sequencer: accepts a start pulse, clamps the vector length and steps
// through element groups, one group per cycle, producing a per-lane mask.
// Assumes MAXVL is a multiple of NLANES and both are powers of two.
module vlane_seq
    import vlane_pkg::*;
#(
    parameter int unsigned NLANES = 4,
    parameter int unsigned NVREG  = 8,
    parameter int unsigned MAXVL  = 64,
    localparam int unsigned VLW   = $clog2(MAXVL + 1),
    localparam int unsigned LW    = $clog2(NLANES),
    localparam int unsigned GW    = $clog2(MAXVL / NLANES),
    localparam int unsigned RW    = $clog2(NVREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  vop_e              op_i,
    input  logic [RW-1:0]     src_a_i,
    input  logic [RW-1:0]     src_b_i,
    input  logic [RW-1:0]     dst_i,
    input  logic [VLW-1:0]    vlen_i,
    output logic              iss_valid,
    output logic              iss_last,
    output logic [GW-1:0]     iss_grp,
    output logic [NLANES-1:0] iss_mask,
    output vop_e              iss_op,
    output logic [RW-1:0]     iss_a,
    output logic [RW-1:0]     iss_b,
    output logic [RW-1:0]     iss_dst,
    output logic              zero_done
);

    logic           busy_q;
    logic [GW-1:0]  grp_q;
    logic [GW-1:0]  last_q;
    logic [VLW-1:0] vl_q;
    vop_e           op_q;
    logic [RW-1:0]  a_q, b_q, d_q;
    logic           zd_q;

    logic [VLW-1:0] vl_eff;
    logic [GW-1:0]  last_g;
    logic           at_last;
    logic           accept;

    // Clamp the requested length and find the index of the final group.
    always_comb begin
        vl_eff = (vlen_i > VLW'(MAXVL)) ? VLW'(MAXVL) : vlen_i;
        last_g = GW'((vl_eff - VLW'(1)) >> LW);
    end

    // Accept a new instruction when idle or on the last issue cycle.
    always_comb begin
        at_last = busy_q && (grp_q == last_q);
        accept  = start && (!busy_q || at_last);
    end

    // Instruction state and group counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            grp_q  <= '0;
            last_q <= '0;
            vl_q   <= '0;
            op_q   <= VOP_ADD;
            a_q    <= '0;
            b_q    <= '0;
            d_q    <= '0;
            zd_q   <= 1'b0;
        end else begin
            zd_q <= accept && (vl_eff == '0);
            if (accept) begin
                if (vl_eff == '0) begin
                    busy_q <= 1'b0;
                end else begin
                    busy_q <= 1'b1;
                    grp_q  <= '0;
                    last_q <= last_g;
                    vl_q   <= vl_eff;
                    op_q   <= op_i;
                    a_q    <= src_a_i;
                    b_q    <= src_b_i;
                    d_q    <= dst_i;
                end
            end else if (at_last) begin
                busy_q <= 1'b0;
            end else if (busy_q) begin
                grp_q <= grp_q + GW'(1);
            end
        end
    end

    // Lane k is active when its element of the current group is below the length.
    for (genvar k = 0; k < NLANES; k++) begin : g_mask
        assign iss_mask[k] = VLW'({grp_q, LW'(k)}) < vl_q;
    end

    assign iss_valid = busy_q;
    assign iss_last  = at_last;
    assign iss_grp   = grp_q;
    assign iss_op    = op_q;
    assign iss_a     = a_q;
    assign iss_b     = b_q;
    assign iss_dst   = d_q;
    assign zero_done = zd_q;

endmodule

// File: rtl/vlane_ctlpipe.sv
`timescale 1ns/1ps
// Control pipeline: carries group index, destination and last-group flag
// alongside the lane datapaths, and produces the completion pulse.
// Assumes the lanes use exactly three register stages from read to write.
module vlane_ctlpipe #(
    parameter int unsigned GW = 4,
    parameter int unsigned RW = 3,
    localparam int unsigned STAGES = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid,
    input  logic          iss_last,
    input  logic [GW-1:0] iss_grp,
    input  logic [RW-1:0] iss_dst,
    input  logic          zero_done,
    output logic [GW-1:0] wr_grp,
    output logic [RW-1:0] wr_dst,
    output logic [GW-1:0] wb_grp,
    output logic [RW-1:0] wb_dst,
    output logic          done
);

    logic [STAGES-1:0] vld_q;
    logic [STAGES-1:0] lst_q;
    logic [GW-1:0]     grp_q [STAGES];
    logic [RW-1:0]     dst_q [STAGES];
    logic              done_q;

    // Shift control fields in step with the lane stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            lst_q  <= '0;
            done_q <= 1'b0;
            for (int i = 0; i < STAGES; i++) begin
                grp_q[i] <= '0;
                dst_q[i] <= '0;
            end
        end else begin
            vld_q    <= {vld_q[STAGES-2:0], iss_valid};
            lst_q    <= {lst_q[STAGES-2:0], iss_valid & iss_last};
            grp_q[0] <= iss_grp;
            dst_q[0] <= iss_dst;
            for (int i = 1; i < STAGES; i++) begin
                grp_q[i] <= grp_q[i-1];
                dst_q[i] <= dst_q[i-1];
            end
            done_q <= vld_q[STAGES-1] & lst_q[STAGES-1];
        end
    end

    assign wr_grp = grp_q[STAGES-2];
    assign wr_dst = dst_q[STAGES-2];
    assign wb_grp = grp_q[STAGES-1];
    assign wb_dst = dst_q[STAGES-1];
    assign done   = done_q | zero_done;

endmodule

// File: rtl/vlane_lane.sv
`timescale 1ns/1ps
// One lane: its bank of every vector register (elements LANE_ID, LANE_ID+NLANES, ...)
// and a three-stage add/subtract pipeline (operand read, compute, write back).
// Assumes DEPTH is a power of two; no forwarding of pending writes.
module vlane_lane
    import vlane_pkg::*;
#(
    parameter int unsigned NVREG   = 8,
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned EW      = 32,
    parameter int unsigned NLANES  = 4,
    parameter int unsigned LANE_ID = 0,
    localparam int unsigned RW     = $clog2(NVREG),
    localparam int unsigned IW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  vop_e          rd_op,
    input  logic [RW-1:0] rd_a,
    input  logic [RW-1:0] rd_b,
    input  logic [IW-1:0] rd_idx,
    input  logic [RW-1:0] wr_dst,
    input  logic [IW-1:0] wr_idx,
    output logic          wb_en_o,
    output logic [EW-1:0] wb_data_o
);

    logic [EW-1:0] bank [NVREG][DEPTH];

    logic          s1_v;
    vop_e          s1_op;
    logic [EW-1:0] s1_a, s1_b;
    logic          s2_v;
    logic [EW-1:0] s2_r;

    // Operand stage: read both sources from this lane's bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v  <= 1'b0;
            s1_op <= VOP_ADD;
            s1_a  <= '0;
            s1_b  <= '0;
        end else begin
            s1_v  <= rd_en;
            s1_op <= rd_op;
            s1_a  <= bank[rd_a][rd_idx];
            s1_b  <= bank[rd_b][rd_idx];
        end
    end

    // Compute stage: wrapping add or subtract.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_v <= 1'b0;
            s2_r <= '0;
        end else begin
            s2_v <= s1_v;
            s2_r <= (s1_op == VOP_SUB) ? (s1_a - s1_b) : (s1_a + s1_b);
        end
    end

    // Write-back stage: update the bank and present the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_en_o   <= 1'b0;
            wb_data_o <= '0;
            for (int unsigned r = 0; r < NVREG; r++) begin
                for (int unsigned j = 0; j < DEPTH; j++) begin
                    bank[r][j] <= EW'(seed_word(r, j * NLANES + LANE_ID));
                end
            end
        end else begin
            wb_en_o   <= s2_v;
            wb_data_o <= s2_r;
            if (s2_v) begin
                bank[wr_dst][wr_idx] <= s2_r;
            end
        end
    end

endmodule

// File: rtl/vlane_addsub.sv
`timescale 1ns/1ps
// Top: multi-lane vector add/subtract unit with internal vector register file.
// Element e lives in and is computed by lane e mod NLANES. One group of NLANES
// elements issues per cycle; results retire three cycles after operand read.
// Assumes NLANES and MAXVL are powers of two with MAXVL >= 2*NLANES.
module vlane_addsub
    import vlane_pkg::*;
#(
    parameter int unsigned NLANES = 4,
    parameter int unsigned NVREG  = 8,
    parameter int unsigned MAXVL  = 64,
    parameter int unsigned EW     = 32,
    localparam int unsigned VLW   = $clog2(MAXVL + 1),
    localparam int unsigned DEPTH = MAXVL / NLANES,
    localparam int unsigned GW    = $clog2(DEPTH),
    localparam int unsigned RW    = $clog2(NVREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 opcode,
    input  logic [RW-1:0]        src_a,
    input  logic [RW-1:0]        src_b,
    input  logic [RW-1:0]        dst,
    input  logic [VLW-1:0]       vlen,
    output logic                 done,
    output logic [NLANES-1:0]    wb_en,
    output logic [RW-1:0]        wb_vreg,
    output logic [GW-1:0]        wb_grp,
    output logic [NLANES*EW-1:0] wb_data
);

    logic              iss_valid;
    logic              iss_last;
    logic [GW-1:0]     iss_grp;
    logic [NLANES-1:0] iss_mask;
    vop_e              iss_op;
    logic [RW-1:0]     iss_a, iss_b, iss_dst;
    logic              zero_done;
    logic [GW-1:0]     wr_grp;
    logic [RW-1:0]     wr_dst;

    vlane_seq #(
        .NLANES (NLANES),
        .NVREG  (NVREG),
        .MAXVL  (MAXVL)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_i      (vop_e'(opcode)),
        .src_a_i   (src_a),
        .src_b_i   (src_b),
        .dst_i     (dst),
        .vlen_i    (vlen),
        .iss_valid (iss_valid),
        .iss_last  (iss_last),
        .iss_grp   (iss_grp),
        .iss_mask  (iss_mask),
        .iss_op    (iss_op),
        .iss_a     (iss_a),
        .iss_b     (iss_b),
        .iss_dst   (iss_dst),
        .zero_done (zero_done)
    );

    vlane_ctlpipe #(
        .GW (GW),
        .RW (RW)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss_valid (iss_valid),
        .iss_last  (iss_last),
        .iss_grp   (iss_grp),
        .iss_dst   (iss_dst),
        .zero_done (zero_done),
        .wr_grp    (wr_grp),
        .wr_dst    (wr_dst),
        .wb_grp    (wb_grp),
        .wb_dst    (wb_vreg),
        .done      (done)
    );

    for (genvar k = 0; k < NLANES; k++) begin : g_lane
        vlane_lane #(
            .NVREG   (NVREG),
            .DEPTH   (DEPTH),
            .EW      (EW),
            .NLANES  (NLANES),
            .LANE_ID (k)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_en     (iss_valid & iss_mask[k]),
            .rd_op     (iss_op),
            .rd_a      (iss_a),
            .rd_b      (iss_b),
            .rd_idx    (iss_grp),
            .wr_dst    (wr_dst),
            .wr_idx    (wr_grp),
            .wb_en_o   (wb_en[k]),
            .wb_data_o (wb_data[k*EW +: EW])
        );
    end

endmodule

// File: rtl/vlane_addsub_chk.sv
`timescale 1ns/1ps
// Checker: temporal properties of the vector unit, bound to the top module.
// Assumes the three-stage lane pipeline of the top.
module vlane_addsub_chk #(
    parameter int unsigned NLANES = 4,
    parameter int unsigned GW     = 4,
    parameter int unsigned RW     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic [NLANES-1:0] wb_en,
    input logic              iss_valid,
    input logic              iss_last,
    input logic [GW-1:0]     iss_grp,
    input logic [RW-1:0]     iss_dst
);

    // R4: enabled lanes form a prefix from lane 0.
    a_r4_prefix_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (|wb_en) |-> ((NLANES'(wb_en + NLANES'(1)) & wb_en) == '0));

    // R5: a write-back is preceded by an issue exactly three cycles earlier.
    a_r5_wb_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (|wb_en) |-> $past(iss_valid, 3));

    // R6 and R7: done follows either a write-back or an accepted start.
    a_r6_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(|wb_en) || $past(start)));

    // R10: groups of one instruction issue on consecutive cycles.
    a_r10_group_step: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && $past(iss_valid) && !$past(iss_last))
        |-> (iss_grp == GW'($past(iss_grp) + GW'(1))));

    // R9: a start before the last issue cycle leaves the instruction unchanged.
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_last) |=> (iss_dst == $past(iss_dst)));

endmodule

bind vlane_addsub vlane_addsub_chk #(
    .NLANES (NLANES),
    .GW     (GW),
    .RW     (RW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .wb_en     (wb_en),
    .iss_valid (iss_valid),
    .iss_last  (iss_last),
    .iss_grp   (iss_grp),
    .iss_dst   (iss_dst)
);

// File: tb/tb_vlane_addsub.sv
`timescale 1ns/1ps
// Bench: behavioural cycle model (arrays and a delay ring) compared every cycle.
module tb_vlane_addsub;

    localparam int NL = 4, NR = 8, MV = 64, SL = 8;

    logic         clk = 1'b0, rst_n = 1'b0, start = 1'b0, opcode = 1'b0;
    logic [2:0]   src_a = '0, src_b = '0, dst = '0;
    logic [6:0]   vlen = '0;
    logic         done;
    logic [3:0]   wb_en;
    logic [2:0]   wb_vreg;
    logic [3:0]   wb_grp;
    logic [127:0] wb_data;

    int n_chk = 0, n_err = 0;
    string ctx = "R1 reset";

    vlane_addsub dut (.clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .src_a(src_a), .src_b(src_b), .dst(dst), .vlen(vlen), .done(done),
        .wb_en(wb_en), .wb_vreg(wb_vreg), .wb_grp(wb_grp), .wb_data(wb_data));

    always #2.5 clk = ~clk;

    // Reference state.
    logic [31:0] mm [NR][MV];
    logic [3:0]  x_en   [SL];
    logic [31:0] x_data [SL][NL];
    int          x_grp  [SL];
    int          x_vreg [SL];
    bit          x_done [SL];
    int cyc = 0;
    bit live = 0;
    bit m_busy;
    int m_grp, m_last, m_vl, m_op, m_a, m_b, m_d;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s [%s]: actual=%h expected=%h", req, ctx, act, exp);
        end
    endtask

    // Model update at each rising edge.
    always @(posedge clk) begin
        int s, t, vl_in, e;
        bit acc, was_last;
        cyc++;
        s = cyc % SL;
        if (!rst_n) begin
            live = 0;
            m_busy = 0;
            for (int r = 0; r < NR; r++)
                for (int i = 0; i < MV; i++)
                    mm[r][i] = 32'(r) * 32'h1000_0000 + 32'(i) * 32'h0100_0101;
            for (int i = 0; i < SL; i++) begin
                x_en[i] = '0; x_done[i] = 0; x_grp[i] = 0; x_vreg[i] = 0;
                for (int k = 0; k < NL; k++) x_data[i][k] = '0;
            end
        end else begin
            live = 1;
            for (int k = 0; k < NL; k++)
                if (x_en[s][k]) mm[x_vreg[s]][x_grp[s] * NL + k] = x_data[s][k];
            vl_in = (int'(vlen) > MV) ? MV : int'(vlen);
            was_last = m_busy && (m_grp == m_last);
            acc = start && (!m_busy || was_last);
            if (acc) begin
                if (vl_in == 0) begin
                    m_busy = 0;
                    x_done[s] = 1;
                end else begin
                    m_busy = 1; m_grp = 0; m_last = (vl_in - 1) / NL; m_vl = vl_in;
                    m_op = int'(opcode); m_a = int'(src_a); m_b = int'(src_b); m_d = int'(dst);
                end
            end else if (was_last) begin
                m_busy = 0;
            end else if (m_busy) begin
                m_grp++;
            end
            if (m_busy) begin
                t = (cyc + 3) % SL;
                x_grp[t] = m_grp;
                x_vreg[t] = m_d;
                for (int k = 0; k < NL; k++) begin
                    e = m_grp * NL + k;
                    if (e < m_vl) begin
                        x_en[t][k] = 1'b1;
                        x_data[t][k] = (m_op == 1) ? mm[m_a][e] - mm[m_b][e] : mm[m_a][e] + mm[m_b][e];
                    end
                end
                if (m_grp == m_last) x_done[(cyc + 4) % SL] = 1;
            end
        end
    end

    // Compare outputs with the model away from the rising edge.
    always @(negedge clk) begin
        int s;
        if (live) begin
            s = cyc % SL;
            chk(done === x_done[s], "R6 R7 done", 32'(done), 32'(x_done[s]));
            chk(wb_en === x_en[s], "R4 R5 lane enables", 32'(wb_en), 32'(x_en[s]));
            if (x_en[s] != '0) begin
                chk(wb_grp === 4'(x_grp[s]), "R3 group index", 32'(wb_grp), 32'(x_grp[s]));
                chk(wb_vreg === 3'(x_vreg[s]), "R3 R11 destination", 32'(wb_vreg), 32'(x_vreg[s]));
            end
            for (int k = 0; k < NL; k++)
                if (x_en[s][k])
                    chk(wb_data[k*32 +: 32] === x_data[s][k], "R2 R3 lane result",
                        wb_data[k*32 +: 32], x_data[s][k]);
            x_en[s] = '0;
            x_done[s] = 0;
        end
    end

    task automatic issue(input bit op, input int a, input int b, input int d, input int vl);
        start = 1'b1; opcode = op; src_a = 3'(a); src_b = 3'(b); dst = 3'(d); vlen = 7'(vl);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R5 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        ctx = "R1 reset";
        chk(done === 1'b0, "R1 done in reset", 32'(done), 0);
        chk(wb_en === 4'b0, "R1 enables in reset", 32'(wb_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        ctx = "R1 R2 full add of reset contents";  issue(0, 0, 1, 2, 64); repeat (24) @(negedge clk);
        ctx = "R2 subtract partial group";         issue(1, 2, 1, 3, 5);  repeat (10) @(negedge clk);
        ctx = "R2 wrap on overflow";               issue(0, 7, 6, 4, 64); repeat (24) @(negedge clk);
        ctx = "R7 zero length";                    issue(0, 1, 1, 5, 0);  repeat (6) @(negedge clk);
        ctx = "R4 length one";                     issue(1, 4, 2, 5, 1);  repeat (8) @(negedge clk);
        ctx = "R4 length three";                   issue(0, 3, 4, 6, 3);  repeat (8) @(negedge clk);
        ctx = "R8 clamp above 64";                 issue(1, 4, 3, 7, 100); repeat (24) @(negedge clk);
        ctx = "R10 back to back";
        issue(0, 1, 2, 6, 10); repeat (2) @(negedge clk);
        issue(1, 6, 1, 7, 7);  repeat (10) @(negedge clk);
        ctx = "R10 single-group back to back";
        issue(0, 0, 1, 1, 4);
        issue(1, 1, 7, 2, 4);  repeat (10) @(negedge clk);
        ctx = "R9 start while busy ignored";
        issue(0, 1, 1, 5, 32); @(negedge clk);
        issue(1, 0, 0, 5, 64); repeat (16) @(negedge clk);
        ctx = "R11 in-place and reread";
        issue(0, 3, 3, 3, 8);  repeat (8) @(negedge clk);
        issue(1, 5, 3, 0, 64); repeat (24) @(negedge clk);
        finish_run();
    end

endmodule